// File: doc/BRIEF.md
# Floating-Point Control and Status Unit

This block holds the floating-point control state of a scalar core: a five-bit sticky exception-flag field and a three-bit rounding-mode field. Software reaches that state through a CSR-style port that offers three windows onto it: a packed 32-bit word holding both fields, a flags-only window and a rounding-only window. Each window supports a plain read and a swap. A swap returns the contents the window had before the access and stores the new data in the same cycle.

Arithmetic units report exception conditions through a separate strobe. Those reports are ORed into the flags, so a flag stays set until software clears it. The unit also serves the instruction side. Each cycle it takes the rounding field of an instruction, replaces the dynamic code with the stored mode, and flags an encoding that cannot be used. All outputs are registered. A result appears one clock after the request.

Top module: `fp_ctl_status_unit`

## Requirements
- R1: A synchronous active-high reset clears the flags, the rounding mode, `csr_rdata`, `rm_eff` and `rm_illegal` to zero.
- R2: When `csr_view`=0 (packed window), the value is {24 zero bits, rounding mode in bits 7:5, flags in bits 4:0}. Bits 31:8 always read as zero, and write data in those bits is discarded.
- R3: When `csr_req` is high, `csr_rdata` in the next cycle shows the window's value from before the access. When `csr_swap` is also high, the selected fields take the new data at that same edge.
- R4: When `csr_view`=1 (flags window), the flags read in bits 4:0 with zeros above. A swap stores only `csr_wdata[4:0]`. The bit order is invalid operation in bit 4, divide-by-zero in bit 3, overflow in bit 2, underflow in bit 1 and inexact in bit 0.
- R5: When `csr_view`=2 (rounding window), the mode reads in bits 2:0 with zeros above. A swap stores only `csr_wdata[2:0]`, and any 3-bit value is accepted into storage.
- R6: When `flag_valid` is high, `flag_bits` are ORed into the flags at the next edge. Set flags stay set until a CSR write clears them.
- R7: A swap through the packed window or the flags window overrides a flag report in the same cycle, and that report is lost. A swap through the rounding window does not block a report that arrives with it.
- R8: When `csr_view`=3, the read value is zero and a swap changes nothing.
- R9: A static instruction mode of 0 to 4 (0 nearest-even, 1 toward zero, 2 down, 3 up, 4 nearest ties-to-max-magnitude) appears unchanged on `rm_eff` one cycle later with `rm_illegal` low. A mode of 5 or 6 raises `rm_illegal`.
- R10: An instruction mode of 7 (dynamic) puts the stored rounding mode on `rm_eff` one cycle later. `rm_illegal` is raised when that stored mode is 5, 6 or 7.
- R11: An access with `csr_swap` low changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_req | input | 1 | CSR access strobe |
| csr_view | input | 2 | Window select: 0 packed, 1 flags, 2 rounding, 3 unused |
| csr_swap | input | 1 | 1 = swap (read old, write new), 0 = read only |
| csr_wdata | input | 32 | Write data for a swap |
| csr_rdata | output | 32 | Window value from before the access, one cycle later |
| flag_valid | input | 1 | Exception report strobe from the arithmetic units |
| flag_bits | input | 5 | Reported exception flags |
| instr_rm | input | 3 | Instruction rounding field |
| rm_eff | output | 3 | Resolved rounding mode, one cycle later |
| rm_illegal | output | 1 | Unusable rounding encoding, one cycle later |

## Verification
Several corner cases get directed tests:
- A swap whose write data is all ones. A design that leaks bits 31:8 into storage reads back a nonzero upper word.
- A report that collides with a flags-window swap, and a report that arrives with a rounding-window swap. A design with the wrong priority keeps the stale report bit, or drops a legitimate one.
- Dynamic resolution while the stored mode holds 5, 6 and 7. A design that checks only the instruction field lets those through as legal.
- Read-only accesses and accesses to the unused window, each read back afterwards. Any stray write shows up in the next read.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  typedef enum logic [1:0] {
    VIEW_ALL   = 2'd0,
    VIEW_FLAGS = 2'd1,
    VIEW_RM    = 2'd2,
    VIEW_NONE  = 2'd3
  } fcsr_view_e;

  // highest rounding encoding that names a real mode; the dynamic code is all ones
  localparam int unsigned RM_LAST_LEGAL = 4;
endpackage

// File: rtl/fcsr_flag_store.sv
module fcsr_flag_store #(
  parameter int unsigned FLAG_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_val,
  input  logic              rep_en,
  input  logic [FLAG_W-1:0] rep_bits,
  output logic [FLAG_W-1:0] flags_q
);
  always_ff @(posedge clk) begin
    if (rst)
      flags_q <= '0;
    else if (wr_en)
      flags_q <= wr_val;             // software write wins over a report
    else if (rep_en)
      flags_q <= flags_q | rep_bits; // sticky accumulation
  end
endmodule

// File: rtl/fcsr_rm_store.sv
module fcsr_rm_store #(
  parameter int unsigned RM_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [RM_W-1:0] wr_val,
  output logic [RM_W-1:0] rm_q
);
  always_ff @(posedge clk) begin
    if (rst)
      rm_q <= '0;
    else if (wr_en)
      rm_q <= wr_val;
  end
endmodule

// File: rtl/fcsr_rm_resolve.sv
module fcsr_rm_resolve
  import fcsr_pkg::*;
#(
  parameter int unsigned RM_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RM_W-1:0] instr_rm,
  input  logic [RM_W-1:0] rm_q,
  output logic [RM_W-1:0] eff_q,
  output logic            illegal_q
);
  localparam logic [RM_W-1:0] DYN_CODE = '1;
  localparam logic [RM_W-1:0] LAST_OK  = RM_W'(RM_LAST_LEGAL);

  logic [RM_W-1:0] pick;
  logic            bad;

  always_comb begin
    pick = (instr_rm == DYN_CODE) ? rm_q : instr_rm;
    bad  = (pick > LAST_OK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      eff_q     <= pick;
      illegal_q <= bad;
    end
  end
endmodule

// File: rtl/fp_ctl_status_unit.sv
module fp_ctl_status_unit
  import fcsr_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned FLAG_W = 5,
  parameter int unsigned RM_W   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            csr_req,
  input  logic [1:0]      csr_view,
  input  logic            csr_swap,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            flag_valid,
  input  logic [FLAG_W-1:0] flag_bits,
  input  logic [RM_W-1:0] instr_rm,
  output logic [RM_W-1:0] rm_eff,
  output logic            rm_illegal
);
  localparam int unsigned RM_LSB  = FLAG_W;
  localparam int unsigned USED_W  = FLAG_W + RM_W;

  fcsr_view_e      view;
  logic            do_swap;
  logic            flag_wr;
  logic            rm_wr;
  logic [RM_W-1:0] rm_wval;
  logic [FLAG_W-1:0] flags_q;
  logic [RM_W-1:0] rm_q;
  logic [XLEN-1:0] rd_next;
  logic            unused_hi;

  assign unused_hi = ^csr_wdata[XLEN-1:USED_W];

  always_comb begin
    view    = fcsr_view_e'(csr_view);
    do_swap = csr_req && csr_swap;
    flag_wr = do_swap && (view == VIEW_ALL || view == VIEW_FLAGS);
    rm_wr   = do_swap && (view == VIEW_ALL || view == VIEW_RM);
    rm_wval = (view == VIEW_ALL) ? csr_wdata[RM_LSB +: RM_W] : csr_wdata[RM_W-1:0];
    rd_next = '0;
    case (view)
      VIEW_ALL:   rd_next[USED_W-1:0] = {rm_q, flags_q};
      VIEW_FLAGS: rd_next[FLAG_W-1:0] = flags_q;
      VIEW_RM:    rd_next[RM_W-1:0]   = rm_q;
      default:    rd_next = '0;
    endcase
  end

  fcsr_flag_store #(.FLAG_W(FLAG_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (flag_wr),
    .wr_val   (csr_wdata[FLAG_W-1:0]),
    .rep_en   (flag_valid),
    .rep_bits (flag_bits),
    .flags_q  (flags_q)
  );

  fcsr_rm_store #(.RM_W(RM_W)) u_rm (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (rm_wr),
    .wr_val (rm_wval),
    .rm_q   (rm_q)
  );

  fcsr_rm_resolve #(.RM_W(RM_W)) u_res (
    .clk       (clk),
    .rst       (rst),
    .instr_rm  (instr_rm),
    .rm_q      (rm_q),
    .eff_q     (rm_eff),
    .illegal_q (rm_illegal)
  );

  always_ff @(posedge clk) begin
    if (rst)
      csr_rdata <= '0;
    else if (csr_req)
      csr_rdata <= rd_next;
  end
endmodule

// File: rtl/fp_ctl_status_unit_chk.sv
module fp_ctl_status_unit_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned FLAG_W = 5,
  parameter int unsigned RM_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              csr_req,
  input logic [1:0]        csr_view,
  input logic              csr_swap,
  input logic [XLEN-1:0]   csr_rdata,
  input logic [RM_W-1:0]   instr_rm,
  input logic [RM_W-1:0]   rm_eff,
  input logic              rm_illegal,
  input logic [FLAG_W-1:0] flags_q,
  input logic [RM_W-1:0]   rm_q
);
  logic flag_touch;
  assign flag_touch = csr_req && csr_swap && (csr_view == 2'd0 || csr_view == 2'd1);

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (flags_q == '0 && rm_q == '0 && csr_rdata == '0));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    csr_rdata[XLEN-1:FLAG_W+RM_W] == '0);

  p_swap_old_r3: assert property (@(posedge clk) disable iff (rst)
    (csr_req && csr_view == 2'd0) |=> csr_rdata[FLAG_W+RM_W-1:0] == {$past(rm_q), $past(flags_q)});

  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    !flag_touch |=> (flags_q & $past(flags_q)) == $past(flags_q));

  p_static_bad_r9: assert property (@(posedge clk) disable iff (rst)
    (instr_rm == 3'd5 || instr_rm == 3'd6) |=> rm_illegal);

  p_dyn_follow_r10: assert property (@(posedge clk) disable iff (rst)
    (instr_rm == 3'd7 && rm_q <= 3'd4) |=> (rm_eff == $past(rm_q) && !rm_illegal));
endmodule

bind fp_ctl_status_unit fp_ctl_status_unit_chk #(.XLEN(XLEN), .FLAG_W(FLAG_W), .RM_W(RM_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .csr_req    (csr_req),
  .csr_view   (csr_view),
  .csr_swap   (csr_swap),
  .csr_rdata  (csr_rdata),
  .instr_rm   (instr_rm),
  .rm_eff     (rm_eff),
  .rm_illegal (rm_illegal),
  .flags_q    (flags_q),
  .rm_q       (rm_q)
);

// File: tb/tb_fp_ctl_status_unit.sv
module tb_fp_ctl_status_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_req = 1'b0;
  logic [1:0]  csr_view = 2'd0;
  logic        csr_swap = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        flag_valid = 1'b0;
  logic [4:0]  flag_bits = '0;
  logic [2:0]  instr_rm = '0;
  logic [2:0]  rm_eff;
  logic        rm_illegal;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fp_ctl_status_unit dut (
    .clk(clk), .rst(rst), .csr_req(csr_req), .csr_view(csr_view), .csr_swap(csr_swap),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .flag_valid(flag_valid), .flag_bits(flag_bits),
    .instr_rm(instr_rm), .rm_eff(rm_eff), .rm_illegal(rm_illegal)
  );

  // {view, swap, wdata, expected rdata}; state starts at zero after reset
  localparam logic [66:0] VEC [8] = '{
    {2'd0, 1'b1, 32'hFFFF_FF5A, 32'h0000_0000},
    {2'd1, 1'b0, 32'h0000_FFFF, 32'h0000_001A},
    {2'd2, 1'b1, 32'hFFFF_FFF4, 32'h0000_0002},
    {2'd1, 1'b1, 32'hFFFF_FFE5, 32'h0000_001A},
    {2'd0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0085},
    {2'd3, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000},
    {2'd0, 1'b1, 32'h0000_0000, 32'h0000_0085},
    {2'd2, 1'b0, 32'h0000_0007, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] v, input logic sw, input logic [31:0] wd,
                        input logic rep, input logic [4:0] rb);
    @(negedge clk);
    csr_req = 1'b1; csr_view = v; csr_swap = sw; csr_wdata = wd;
    flag_valid = rep; flag_bits = rb;
    @(negedge clk);
    csr_req = 1'b0; csr_swap = 1'b0; flag_valid = 1'b0; flag_bits = '0;
  endtask

  task automatic report(input logic [4:0] rb);
    @(negedge clk);
    flag_valid = 1'b1; flag_bits = rb;
    @(negedge clk);
    flag_valid = 1'b0; flag_bits = '0;
  endtask

  task automatic resolve(input logic [2:0] m);
    @(negedge clk);
    instr_rm = m;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rdata after reset", csr_rdata, 32'h0);
    chk("R1 rm_eff after reset", {29'd0, rm_eff}, 32'h0);
    chk("R1 rm_illegal after reset", {31'd0, rm_illegal}, 32'h0);
    access(2'd0, 1'b0, 32'h0, 1'b0, 5'd0);
    chk("R1 packed state after reset", csr_rdata, 32'h0);

    // vector walk covering R2, R3, R4, R5, R8, R11
    for (int i = 0; i < 8; i++) begin
      access(VEC[i][66:65], VEC[i][64], VEC[i][63:32], 1'b0, 5'd0);
      chk($sformatf("R2/R3/R4/R5/R8/R11 vector %0d", i), csr_rdata, VEC[i][31:0]);
    end

    // R6: reports accumulate and stick
    report(5'b00001);
    report(5'b10000);
    report(5'b00000);
    access(2'd1, 1'b0, 32'h0, 1'b0, 5'd0);
    chk("R6 sticky flags", csr_rdata, 32'h11);

    // R7: flags swap wins over a same-cycle report
    access(2'd1, 1'b1, 32'h0000_0002, 1'b1, 5'b00100);
    chk("R7 swap returns old flags", csr_rdata, 32'h11);
    access(2'd1, 1'b0, 32'h0, 1'b0, 5'd0);
    chk("R7 report dropped under write", csr_rdata, 32'h02);
    // R7: rounding window swap leaves the report intact
    access(2'd2, 1'b1, 32'h0000_0001, 1'b1, 5'b01000);
    access(2'd0, 1'b0, 32'h0, 1'b0, 5'd0);
    chk("R7 report kept beside rm write", csr_rdata, 32'h2A);

    // R11: read-only access with data present changes nothing
    access(2'd0, 1'b0, 32'hFFFF_FFFF, 1'b0, 5'd0);
    chk("R11 read-only no write", csr_rdata, 32'h2A);

    // R9: static modes
    for (int m = 0; m < 5; m++) begin
      resolve(3'(m));
      chk($sformatf("R9 static mode %0d", m), {28'd0, rm_illegal, rm_eff}, {28'd0, 1'b0, 3'(m)});
    end
    resolve(3'd5);
    chk("R9 static 5 illegal", {31'd0, rm_illegal}, 32'h1);
    resolve(3'd6);
    chk("R9 static 6 illegal", {31'd0, rm_illegal}, 32'h1);

    // R10: dynamic resolution
    access(2'd2, 1'b1, 32'h3, 1'b0, 5'd0);
    resolve(3'd7);
    chk("R10 dynamic follows stored 3", {28'd0, rm_illegal, rm_eff}, {28'd0, 1'b0, 3'd3});
    for (int m = 5; m < 8; m++) begin
      access(2'd2, 1'b1, 32'(m), 1'b0, 5'd0);
      resolve(3'd7);
      chk($sformatf("R10 dynamic stored %0d illegal", m), {31'd0, rm_illegal}, 32'h1);
    end

    // R1: reset mid-run clears everything
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    access(2'd0, 1'b0, 32'h0, 1'b0, 5'd0);
    chk("R1 state cleared by reset", csr_rdata, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule